// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block steps through a control store of microinstructions and presents the micro-operation bits of the current word to a datapath. Each control word packs three fields. The most significant field holds the micro-operation bits. The middle field holds a flag selector. The least significant field holds a branch target. The store is a constant table that is computed when the design is built. It holds a test program whose contents are a fixed function of the address.

Every microinstruction takes two clock cycles. In the first cycle the word at the current control address is read into a register. In the second cycle its micro-operation bits are presented with a valid strobe, and the control address moves on. The next address is one of three:
- the branch target, when the selected flag is true;
- the current address plus one, when the selected flag is false;
- an address derived from the opcode, when the word requests dispatch.

Dispatch places each opcode's routine on an eight-word boundary. The address width is a parameter: the default is 8 bits (256 words), and a 10-bit variant is supported.

Top module: `ucseq_top`

## Requirements
- R1: A control word is laid out as follows:
  - micro-operation bits in the top 13 bits, on output `uop`;
  - the 3-bit flag selector directly below them;
  - the branch target, ADDR_W bits wide, in the least significant bits.
- R2: While `rstN` is low, `ctrlAddr` is 0 and `uopValid` is 0. The first valid word after reset is the word at address 0.
- R3: `uopValid` alternates: it is low for one cycle while a word is read, then high for one cycle. `ctrlAddr` changes only on the clock edge that ends a cycle in which `uopValid` is high.
- R4: On that edge, a word that is not a dispatch word loads its branch target into `ctrlAddr` when `flags[sel]` is 1.
- R5: On that edge, when `sel` is nonzero and `flags[sel]` is 0, `ctrlAddr` becomes `ctrlAddr + 1` modulo 2^ADDR_W.
- R6: Selector value 0 always takes the branch, and input `flags[0]` has no effect.
- R7: A word whose `uop[12:11]` equals 2'b11 is a dispatch word. Dispatch takes precedence over the flag test and loads `ctrlAddr` with `opcode * 8`, zero-extended to ADDR_W bits.
- R8: With ADDR_W = 10, opcode 5'b00010 dispatches to 10'h010 and opcode 5'b11111 dispatches to 10'h0F8. With the default ADDR_W = 8, the same two opcodes dispatch to 8'h10 and 8'hF8.
- R9: The test program holds the following word at address a:
  - `uop` = a in its low bits, with `uop[12:11]` forced to 2'b11 when a mod 8 = 7;
  - selector = ((a mod 8) + (a div 8)) mod 8;
  - branch target = (a + 19) mod 2^ADDR_W.
  When `uopValid` is high, `uop` shows the word at the current `ctrlAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opcode | input | 5 | Opcode used on dispatch |
| flags | input | 8 | Status flags; bit 0 is ignored |
| uop | output | 13 | Micro-operation bits of the current word |
| uopValid | output | 1 | High in the cycle in which `uop` is valid |
| ctrlAddr | output | ADDR_W (8) | Current control address |

## Verification
The bound checker examines every cycle. It checks that the valid strobe alternates and that the address holds still during reads. On every valid cycle it checks which of the three next-address sources was taken: the branch target, the increment, or the opcode map.

Only the bench scenarios can show the following:
- that the output word matches the computed program at each address;
- that the behaviour after a reset in the middle of a run is correct;
- that flag 0 is ignored across whole runs;
- that the 10-bit variant maps the two named opcodes to their stated addresses.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;
  typedef enum logic [1:0] {SEL_INC, SEL_BRANCH, SEL_MAP} nextSel_t;
  typedef enum logic {PH_FETCH, PH_EXEC} phase_t;
  typedef struct packed {
    logic     fetchEn;
    logic     stepEn;
    nextSel_t nextSel;
  } seqStrobe_t;
  localparam logic [1:0] DISPATCH_CODE = 2'b11;
endpackage

// File: rtl/ucseq_ctrl.sv
module ucseq_ctrl
  import ucseq_pkg::*;
#(
  parameter int COND_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           uopTop,
  input  logic [COND_W-1:0]    condSel,
  input  logic [2**COND_W-1:0] flags,
  output seqStrobe_t           strobe,
  output logic                 uopValid
);
  localparam int NFLAG = 2**COND_W;

  phase_t phase;
  logic [NFLAG-1:0] flagVec;

  // Selector 0 is tied to true whatever flags[0] carries.
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    if (i == 0) begin : g_const
      assign flagVec[i] = 1'b1 | flags[i];
    end else begin : g_ext
      assign flagVec[i] = flags[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_FETCH;
    else       phase <= (phase == PH_FETCH) ? PH_EXEC : PH_FETCH;
  end

  always_comb begin
    strobe.fetchEn = (phase == PH_FETCH);
    strobe.stepEn  = (phase == PH_EXEC);
    if (uopTop == DISPATCH_CODE)  strobe.nextSel = SEL_MAP;
    else if (flagVec[condSel])    strobe.nextSel = SEL_BRANCH;
    else                          strobe.nextSel = SEL_INC;
  end

  assign uopValid = (phase == PH_EXEC);
endmodule

// File: rtl/ucseq_path.sv
module ucseq_path
  import ucseq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int UOP_W      = 13,
  parameter int COND_W     = 3,
  parameter int OPC_W      = 5,
  parameter int ROUTINE_LG = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  seqStrobe_t                        strobe,
  input  logic [OPC_W-1:0]                  opcode,
  output logic [ADDR_W-1:0]                 ctrlAddr,
  output logic [UOP_W+COND_W+ADDR_W-1:0]    ctrlWord
);
  localparam int WORD_W = UOP_W + COND_W + ADDR_W;
  localparam int DEPTH  = 2**ADDR_W;
  localparam int MAP_W  = OPC_W + ROUTINE_LG;
  localparam int PAD_W  = ADDR_W - MAP_W;

  function automatic logic [WORD_W-1:0] progWord(input int a);
    logic [UOP_W-1:0]  u;
    logic [COND_W-1:0] c;
    logic [ADDR_W-1:0] n;
    u = UOP_W'(a);
    if ((a % 8) == 7) u[UOP_W-1 -: 2] = DISPATCH_CODE;
    c = COND_W'(((a % 8) + (a / 8)) % (2**COND_W));
    n = ADDR_W'((a + 19) % DEPTH);
    return {u, c, n};
  endfunction

  logic [WORD_W-1:0] rom [DEPTH];
  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = progWord(i);
  end

  logic [ADDR_W-1:0] mapAddr;
  if (PAD_W > 0) begin : g_pad
    assign mapAddr = {{PAD_W{1'b0}}, opcode, {ROUTINE_LG{1'b0}}};
  end else begin : g_nopad
    assign mapAddr = {opcode, {ROUTINE_LG{1'b0}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlAddr <= '0;
      ctrlWord <= '0;
    end else begin
      if (strobe.fetchEn) ctrlWord <= rom[ctrlAddr];
      if (strobe.stepEn) begin
        case (strobe.nextSel)
          SEL_MAP:    ctrlAddr <= mapAddr;
          SEL_BRANCH: ctrlAddr <= ctrlWord[ADDR_W-1:0];
          default:    ctrlAddr <= ctrlAddr + 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/ucseq_top.sv
module ucseq_top
  import ucseq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int UOP_W  = 13,
  parameter int COND_W = 3,
  parameter int OPC_W  = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [OPC_W-1:0]     opcode,
  input  logic [2**COND_W-1:0] flags,
  output logic [UOP_W-1:0]     uop,
  output logic                 uopValid,
  output logic [ADDR_W-1:0]    ctrlAddr
);
  localparam int WORD_W = UOP_W + COND_W + ADDR_W;

  seqStrobe_t        strobe;
  logic [WORD_W-1:0] ctrlWord;

  ucseq_ctrl #(.COND_W(COND_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .uopTop   (ctrlWord[WORD_W-1 -: 2]),
    .condSel  (ctrlWord[ADDR_W +: COND_W]),
    .flags    (flags),
    .strobe   (strobe),
    .uopValid (uopValid)
  );

  ucseq_path #(
    .ADDR_W(ADDR_W), .UOP_W(UOP_W), .COND_W(COND_W), .OPC_W(OPC_W), .ROUTINE_LG(3)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opcode   (opcode),
    .ctrlAddr (ctrlAddr),
    .ctrlWord (ctrlWord)
  );

  assign uop = ctrlWord[WORD_W-1 -: UOP_W];
endmodule

// File: rtl/ucseq_chk.sv
module ucseq_chk #(
  parameter int ADDR_W = 8,
  parameter int UOP_W  = 13,
  parameter int COND_W = 3,
  parameter int OPC_W  = 5
) (
  input logic                              clk,
  input logic                              rstN,
  input logic [OPC_W-1:0]                  opcode,
  input logic [2**COND_W-1:0]              flags,
  input logic                              uopValid,
  input logic [ADDR_W-1:0]                 ctrlAddr,
  input logic [UOP_W+COND_W+ADDR_W-1:0]    ctrlWord
);
  localparam int WORD_W = UOP_W + COND_W + ADDR_W;

  logic              isDisp;
  logic [COND_W-1:0] selF;
  logic              selTrue;
  assign isDisp  = (ctrlWord[WORD_W-1 -: 2] == 2'b11);
  assign selF    = ctrlWord[ADDR_W +: COND_W];
  assign selTrue = (selF == '0) || flags[selF];

  // R3
  valid_alternate_chk: assert property (@(posedge clk) disable iff (!rstN)
    uopValid |=> !uopValid);
  // R3
  valid_follows_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !uopValid |=> uopValid);
  // R3
  addr_hold_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !uopValid |=> $stable(ctrlAddr));
  // R4
  branch_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && !isDisp && selTrue) |=> ctrlAddr == $past(ctrlWord[ADDR_W-1:0]));
  // R5
  increment_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && !isDisp && !selTrue) |=> ctrlAddr == ADDR_W'($past(ctrlAddr) + 1));
  // R7
  dispatch_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && isDisp) |=> ctrlAddr == (ADDR_W'($past(opcode)) << 3));
endmodule

bind ucseq_top ucseq_chk #(
  .ADDR_W(ADDR_W), .UOP_W(UOP_W), .COND_W(COND_W), .OPC_W(OPC_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .opcode   (opcode),
  .flags    (flags),
  .uopValid (uopValid),
  .ctrlAddr (ctrlAddr),
  .ctrlWord (ctrlWord)
);

// File: tb/tb_ucseq_top.sv
`timescale 1ns/1ps
module tb_ucseq_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  opcode = '0;
  logic [7:0]  flags = '0;
  logic [12:0] uopN, uopW;
  logic        vldN, vldW;
  logic [7:0]  addrN;
  logic [9:0]  addrW;

  always #5 clk = ~clk;

  ucseq_top dut (.clk(clk), .rstN(rstN), .opcode(opcode), .flags(flags),
                 .uop(uopN), .uopValid(vldN), .ctrlAddr(addrN));
  ucseq_top #(.ADDR_W(10)) dutWide (.clk(clk), .rstN(rstN), .opcode(opcode), .flags(flags),
                 .uop(uopW), .uopValid(vldW), .ctrlAddr(addrW));

  int compared = 0;
  int mismatched = 0;
  int mCar [2];
  int mPh  [2];
  int depthOf [2] = '{256, 1024};
  int dispTo16 = 0;
  int dispTo248 = 0;
  bit finished = 0;

  function automatic int refUop(int a);
    int u = a & 'h7FF;
    if (a % 8 == 7) u = u | 'h1800;
    return u;
  endfunction

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int k = 0; k < 2; k++) begin mCar[k] = 0; mPh[k] = 0; end
  endtask

  // advance model by the edge just passed, using inputs held since last negedge
  task automatic modelStep();
    for (int k = 0; k < 2; k++) begin
      if (mPh[k] == 0) mPh[k] = 1;
      else begin
        int a = mCar[k];
        int c = ((a % 8) + (a / 8)) % 8;
        if ((refUop(a) >> 11) == 3) begin
          mCar[k] = opcode * 8;
          if (opcode == 5'd2)  begin dispTo16++;  check(k ? "R8 wide map" : "R8 map", k ? addrW : addrN, 'h10); end
          if (opcode == 5'd31) begin dispTo248++; check(k ? "R8 wide map" : "R8 map", k ? addrW : addrN, 'hF8); end
        end else if (c == 0 || flags[c]) mCar[k] = (a + 19) % depthOf[k];
        else mCar[k] = (a + 1) % depthOf[k];
        mPh[k] = 0;
      end
    end
  endtask

  task automatic compareAll();
    check("R3 valid", vldN, mPh[0]);
    check("R3 valid wide", vldW, mPh[1]);
    check("R4/R5/R6/R7 addr", addrN, mCar[0]);
    check("R4/R5/R6/R7 addr wide", addrW, mCar[1]);
    if (mPh[0] == 1) check("R1/R9 uop", uopN, refUop(mCar[0]));
    if (mPh[1] == 1) check("R1/R9 uop wide", uopW, refUop(mCar[1]));
  endtask

  // mode: 0 random, 1 opcode 2, 2 opcode 31, 3 flags all low, 4 only flag0, 5 all nonzero flags high
  task automatic run(int n, int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rstN) modelStep();
      compareAll();
      case (mode)
        1: begin opcode = 5'd2;  flags = 8'($urandom); end
        2: begin opcode = 5'd31; flags = 8'($urandom); end
        3: begin opcode = 5'($urandom); flags = 8'h00; end
        4: begin opcode = 5'($urandom); flags = 8'h01; end
        5: begin opcode = 5'($urandom); flags = 8'hFE; end
        default: begin opcode = 5'($urandom); flags = 8'($urandom); end
      endcase
    end
  endtask

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    // R2 reset state
    check("R2 reset addr", addrN, 0);
    check("R2 reset valid", vldN, 0);
    rstN = 1'b1;
    run(1, 0);
    run(1, 0);
    // R2 first valid word is the one at address 0
    check("R2 first word", uopN, refUop(0));
    run(1500, 0);
    run(1500, 1);
    run(1500, 2);
    run(600, 3);
    run(600, 4);
    run(600, 5);
    // reset in the middle of a run
    @(negedge clk);
    rstN = 1'b0;
    #1;
    modelReset();
    check("R2 async addr", addrN, 0);
    check("R2 async valid", vldN, 0);
    check("R2 async addr wide", addrW, 0);
    run(3, 0);
    @(negedge clk);
    rstN = 1'b1;
    run(1500, 0);
    check("R7 dispatch to opcode 2 seen", int'(dispTo16 > 0), 1);
    check("R7 dispatch to opcode 31 seen", int'(dispTo248 > 0), 1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule